// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit RISC core that runs in one of six operating modes: one unprivileged mode and five privileged ones (fast interrupt, normal interrupt, supervisor, abort and undefined). Software always addresses sixteen registers by a 4-bit number. The block remaps each number to a physical slot that depends on the current mode, so that privileged handlers get private copies of some registers without saving the ones the interrupted code was using. The storage is 31 general-purpose slots and 6 status registers: one current status register and one saved status register per privileged mode.

Two combinational read ports and one clocked write port serve the datapath. Register 15 is the program counter. It can be loaded through the write port or through a separate PC load input, and it is read back word-aligned. A branch-and-link strobe saves the aligned PC into the link register (R14) of the current mode. An exception-entry strobe switches the mode, saves the current status word and stores the return PC into the target mode's private link register, all on one edge. The active mode is the decoded low three bits of the current status register.

Top module: `bankreg_file`

## Requirements
- R1: `rst_n` low resets asynchronously, and its release is synchronised through two flops. After reset every general slot and the PC are zero, `cpsr_o` is 0x00000003 (supervisor) and `mode_o` is 3.
- R2: `ra_data`, `rb_data` and `sr_rdata` follow their addresses in the same cycle with no clock. A write through `wr_en`/`wr_addr`/`wr_data` becomes visible only after the next rising edge.
- R3: R0 to R7 name the same physical registers in every mode.
- R4: In fast-interrupt mode (1), R8 to R14 are private to that mode. In modes 2 to 5, R13 and R14 are private to each mode. Every other number maps to the shared user copy.
- R5: A read of R15 on either port returns the PC with bits [1:0] cleared, while `pc_o` gives all stored bits. A write-port access to R15 loads `wr_data` into the PC. Otherwise `pc_ld` loads `pc_in`. The write port wins if both occur in the same cycle.
- R6: `bl_en` stores the aligned PC into R14 of the current mode. It overrides a write-port access to that same R14 in the same cycle.
- R7: `exc_en` with `exc_mode` in 1..5 does three things on one edge: it copies the current status word into the target mode's saved status register, it replaces bits [2:0] of the current status word with `exc_mode` while keeping the other bits, and it writes the aligned PC into the target mode's R14. With `exc_mode` 0, 6 or 7 the strobe has no effect.
- R8: In a cycle with a valid exception entry, the status write port is ignored. The write port and `bl_en` still act on the registers of the old mode. The exception's R14 write wins over either of them when they hit the same slot.
- R9: Mode encoding: 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. Status bits [2:0] equal to 6 or 7 behave as user, and `mode_o` then reads 0.
- R10: `sr_rsel`=0 reads the current status word. `sr_rsel`=1 reads the current mode's saved status word in a privileged mode and the current status word in user mode.
- R11: `sr_wen` with `sr_wsel`=0 writes all 32 bits of the current status word. With `sr_wsel`=1 it writes the current mode's saved status word in a privileged mode and is ignored in user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| pc_ld | input | 1 | Load PC from pc_in |
| pc_in | input | 32 | Next PC value |
| bl_en | input | 1 | Branch-and-link: save PC into current R14 |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 3 | Target mode of exception entry |
| sr_wen | input | 1 | Status register write enable |
| sr_wsel | input | 1 | Status write target: 0 current, 1 saved |
| sr_wdata | input | 32 | Status write data |
| sr_rsel | input | 1 | Status read select: 0 current, 1 saved |
| sr_rdata | output | 32 | Status read data |
| cpsr_o | output | 32 | Current status word |
| mode_o | output | 3 | Decoded current mode |
| pc_o | output | 32 | Stored PC, unmasked |

## Verification
The bench builds the block with its default 32-bit data width and supervisor reset word. With these values, PC values whose low two bits are set reach the R15 masking path, and mode bits written straight into the status word reach the invalid encodings 6 and 7. A reference model keeps separate user, fast-interrupt and per-mode banks. Random mode switches, made both by exception entry and by status writes, drive every read address through every bank. Directed cycles force the same-cycle collisions of branch-and-link, exception entry, the write port and status writes.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } mode_e;

  localparam int MODE_W        = 3;
  localparam int AREG_W        = 4;
  localparam int NUM_AREG      = 1 << AREG_W;
  localparam int PC_REG        = NUM_AREG - 1;
  localparam int LINK_REG      = NUM_AREG - 2;
  localparam int FIQ_FIRST     = 8;
  localparam int PRV_FIRST     = 13;
  localparam int FIQ_BANK      = LINK_REG - FIQ_FIRST + 1;
  localparam int PRV_BANK      = LINK_REG - PRV_FIRST + 1;
  localparam int NUM_PRV_MODES = 4;
  localparam int FIQ_BASE      = NUM_AREG;
  localparam int PRV_BASE      = FIQ_BASE + FIQ_BANK;
  localparam int NUM_SLOT      = PRV_BASE + NUM_PRV_MODES * PRV_BANK;
  localparam int SLOT_W        = $clog2(NUM_SLOT);
  localparam int NUM_SPSR      = 5;
  localparam int SPSR_W        = $clog2(NUM_SPSR);

  // Raw mode bits to a legal mode; unused codes fall back to user.
  function automatic mode_e mode_decode(input logic [MODE_W-1:0] raw);
    if (raw > 3'd5) return MODE_USR;
    return mode_e'(raw);
  endfunction

  function automatic logic mode_raw_priv(input logic [MODE_W-1:0] raw);
    return (raw >= 3'd1) && (raw <= 3'd5);
  endfunction

endpackage

// File: rtl/bankreg_map.sv
`timescale 1ns/1ps
module bankreg_map
  import bankreg_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [AREG_W-1:0] areg_i,
  output logic [SLOT_W-1:0] slot_o
);

  logic fiq_hit;
  logic prv_hit;

  always_comb begin
    fiq_hit = (mode_i == MODE_FIQ) &&
              (areg_i >= AREG_W'(FIQ_FIRST)) && (areg_i <= AREG_W'(LINK_REG));
    prv_hit = (mode_i != MODE_USR) && (mode_i != MODE_FIQ) &&
              (areg_i >= AREG_W'(PRV_FIRST)) && (areg_i <= AREG_W'(LINK_REG));
  end

  always_comb begin
    slot_o = SLOT_W'(areg_i);
    if (fiq_hit) begin
      slot_o = SLOT_W'(FIQ_BASE + int'(areg_i) - FIQ_FIRST);
    end else if (prv_hit) begin
      slot_o = SLOT_W'(PRV_BASE + (int'(mode_i) - int'(MODE_IRQ)) * PRV_BANK
                       + int'(areg_i) - PRV_FIRST);
    end
  end

endmodule

// File: rtl/bankreg_gpr.sv
`timescale 1ns/1ps
module bankreg_gpr
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              bl_hit,
  input  logic [SLOT_W-1:0] bl_slot,
  input  logic              ex_hit,
  input  logic [SLOT_W-1:0] ex_slot,
  input  logic [DATA_W-1:0] link_val,
  input  logic              pc_ld,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [SLOT_W-1:0] rd_a_slot,
  input  logic [SLOT_W-1:0] rd_b_slot,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] pc_q
);

  logic [DATA_W-1:0] mem_q  [NUM_SLOT];
  logic [DATA_W-1:0] mem_d  [NUM_SLOT];
  logic              mem_en [NUM_SLOT];

  generate
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
      logic hit_w;
      logic hit_b;
      logic hit_e;
      assign hit_w = wr_hit && (wr_slot == SLOT_W'(s));
      assign hit_b = bl_hit && (bl_slot == SLOT_W'(s));
      assign hit_e = ex_hit && (ex_slot == SLOT_W'(s));
      if (s == PC_REG) begin : g_pc
        always_comb begin
          mem_en[s] = hit_w || pc_ld;
          mem_d[s]  = hit_w ? wr_val : pc_val;
        end
      end else begin : g_gen
        // Link writes (branch-and-link or exception) override the write port.
        always_comb begin
          mem_en[s] = hit_w || hit_b || hit_e;
          mem_d[s]  = (hit_b || hit_e) ? link_val : wr_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOT; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOT; i++) begin
        if (mem_en[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  assign rd_a = mem_q[rd_a_slot];
  assign rd_b = mem_q[rd_b_slot];
  assign pc_q = mem_q[PC_REG];

  AST_BL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    bl_hit |=> mem_q[$past(bl_slot)] == $past(link_val)); // R6

  AST_EXC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    ex_hit |=> mem_q[$past(ex_slot)] == $past(link_val)); // R7

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && !(wr_hit && wr_slot == SLOT_W'(PC_REG))) |=> pc_q == $past(pc_val)); // R5

endmodule

// File: rtl/bankreg_psr.sv
`timescale 1ns/1ps
module bankreg_psr
  import bankreg_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_CPSR = DATA_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_go,
  input  mode_e             ex_mode,
  input  logic              sr_wen,
  input  logic              sr_wsel,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              sr_rsel,
  output logic [DATA_W-1:0] sr_rdata,
  output logic [DATA_W-1:0] cpsr_q,
  output mode_e             cur_mode
);

  logic [DATA_W-1:0] spsr_q [NUM_SPSR];
  logic [DATA_W-1:0] cpsr_d;
  logic              cpsr_en;
  logic [DATA_W-1:0] spsr_d;
  logic              spsr_en;
  logic [SPSR_W-1:0] spsr_idx;
  logic [SPSR_W-1:0] cur_idx;
  logic              cur_priv;

  assign cur_mode = mode_decode(cpsr_q[MODE_W-1:0]);
  assign cur_priv = (cur_mode != MODE_USR);
  assign cur_idx  = SPSR_W'(int'(cur_mode) - 1);

  always_comb begin
    cpsr_en  = 1'b0;
    cpsr_d   = cpsr_q;
    spsr_en  = 1'b0;
    spsr_idx = cur_idx;
    spsr_d   = sr_wdata;
    if (ex_go) begin
      cpsr_en  = 1'b1;
      cpsr_d   = {cpsr_q[DATA_W-1:MODE_W], ex_mode};
      spsr_en  = 1'b1;
      spsr_idx = SPSR_W'(int'(ex_mode) - 1);
      spsr_d   = cpsr_q;
    end else if (sr_wen && !sr_wsel) begin
      cpsr_en  = 1'b1;
      cpsr_d   = sr_wdata;
    end else if (sr_wen && sr_wsel && cur_priv) begin
      spsr_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q <= RST_CPSR;
    end else if (cpsr_en) begin
      cpsr_q <= cpsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPSR; i++) spsr_q[i] <= '0;
    end else if (spsr_en) begin
      spsr_q[spsr_idx] <= spsr_d;
    end
  end

  assign sr_rdata = (sr_rsel && cur_priv) ? spsr_q[cur_idx] : cpsr_q;

  AST_EXC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_go |=> cur_mode == $past(ex_mode)); // R7

  AST_EXC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_go |=> spsr_q[SPSR_W'(int'($past(ex_mode)) - 1)] == $past(cpsr_q)); // R7

  AST_USER_SPSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wen && sr_wsel && !cur_priv && !ex_go) |=> $stable(cpsr_q)); // R11

endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_CPSR = DATA_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_ld,
  input  logic [DATA_W-1:0] pc_in,
  input  logic              bl_en,
  input  logic              exc_en,
  input  logic [2:0]        exc_mode,
  input  logic              sr_wen,
  input  logic              sr_wsel,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              sr_rsel,
  output logic [DATA_W-1:0] sr_rdata,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [2:0]        mode_o,
  output logic [DATA_W-1:0] pc_o
);

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mode_e             cur_mode;
  mode_e             ex_mode_e;
  logic              ex_go;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] pc_aligned;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [SLOT_W-1:0] slot_a;
  logic [SLOT_W-1:0] slot_b;
  logic [SLOT_W-1:0] slot_w;
  logic [SLOT_W-1:0] slot_bl;
  logic [SLOT_W-1:0] slot_ex;

  assign ex_go      = exc_en && mode_raw_priv(exc_mode);
  assign ex_mode_e  = mode_decode(exc_mode);
  assign pc_aligned = {pc_q[DATA_W-1:2], 2'b00};

  bankreg_map u_map_a  (.mode_i(cur_mode),  .areg_i(ra_addr),           .slot_o(slot_a));
  bankreg_map u_map_b  (.mode_i(cur_mode),  .areg_i(rb_addr),           .slot_o(slot_b));
  bankreg_map u_map_w  (.mode_i(cur_mode),  .areg_i(wr_addr),           .slot_o(slot_w));
  bankreg_map u_map_bl (.mode_i(cur_mode),  .areg_i(AREG_W'(LINK_REG)), .slot_o(slot_bl));
  bankreg_map u_map_ex (.mode_i(ex_mode_e), .areg_i(AREG_W'(LINK_REG)), .slot_o(slot_ex));

  bankreg_gpr #(.DATA_W(DATA_W)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_hit    (wr_en),
    .wr_slot   (slot_w),
    .wr_val    (wr_data),
    .bl_hit    (bl_en),
    .bl_slot   (slot_bl),
    .ex_hit    (ex_go),
    .ex_slot   (slot_ex),
    .link_val  (pc_aligned),
    .pc_ld     (pc_ld),
    .pc_val    (pc_in),
    .rd_a_slot (slot_a),
    .rd_b_slot (slot_b),
    .rd_a      (rd_a),
    .rd_b      (rd_b),
    .pc_q      (pc_q)
  );

  bankreg_psr #(.DATA_W(DATA_W), .RST_CPSR(RST_CPSR)) u_psr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ex_go    (ex_go),
    .ex_mode  (ex_mode_e),
    .sr_wen   (sr_wen),
    .sr_wsel  (sr_wsel),
    .sr_wdata (sr_wdata),
    .sr_rsel  (sr_rsel),
    .sr_rdata (sr_rdata),
    .cpsr_q   (cpsr_o),
    .cur_mode (cur_mode)
  );

  assign ra_data = (ra_addr == AREG_W'(PC_REG)) ? pc_aligned : rd_a;
  assign rb_data = (rb_addr == AREG_W'(PC_REG)) ? pc_aligned : rd_b;
  assign mode_o  = cur_mode;
  assign pc_o    = pc_q;

  AST_PC_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && wr_addr == AREG_W'(PC_REG)) |=> pc_o == $past(wr_data)); // R5

endmodule

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ra_addr, rb_addr, wr_addr;
  logic [31:0] ra_data, rb_data, wr_data, pc_in, sr_wdata, sr_rdata, cpsr_o, pc_o;
  logic        wr_en, pc_ld, bl_en, exc_en, sr_wen, sr_wsel, sr_rsel;
  logic [2:0]  exc_mode, mode_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string focus = "";

  // Reference state, laid out by bank rather than by slot.
  logic [31:0] m_usr [15];
  logic [31:0] m_fiq [7];
  logic [31:0] m_prv [4][2];
  logic [31:0] m_pc, m_cpsr;
  logic [31:0] m_spsr [6];

  always #5 clk = ~clk;

  bankreg_file uut (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_ld(pc_ld), .pc_in(pc_in), .bl_en(bl_en),
    .exc_en(exc_en), .exc_mode(exc_mode),
    .sr_wen(sr_wen), .sr_wsel(sr_wsel), .sr_wdata(sr_wdata),
    .sr_rsel(sr_rsel), .sr_rdata(sr_rdata),
    .cpsr_o(cpsr_o), .mode_o(mode_o), .pc_o(pc_o)
  );

  function automatic int cur_m();
    return (m_cpsr[2:0] > 3'd5) ? 0 : int'(m_cpsr[2:0]);
  endfunction

  function automatic logic [31:0] pc_al();
    return {m_pc[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] mget(int md, int r);
    if (r == 15) return pc_al();
    if (md == 1 && r >= 8) return m_fiq[r-8];
    if (md >= 2 && r >= 13) return m_prv[md-2][r-13];
    return m_usr[r];
  endfunction

  task automatic mset(int md, int r, logic [31:0] v);
    if (md == 1 && r >= 8) m_fiq[r-8] = v;
    else if (md >= 2 && r >= 13) m_prv[md-2][r-13] = v;
    else m_usr[r] = v;
  endtask

  function automatic string tag_of(int a);
    if (focus != "") return focus;
    if (a == 15) return "R5";
    if (a >= 8) return "R4";
    return "R3";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_prv[i][0] = '0; m_prv[i][1] = '0; end
    for (int i = 0; i < 6; i++) m_spsr[i] = '0;
    m_pc = '0;
    m_cpsr = 32'h3;
  endtask

  task automatic model_step();
    int cm;
    logic [31:0] pa;
    bit exv;
    cm = cur_m();
    pa = pc_al();
    exv = exc_en && exc_mode >= 3'd1 && exc_mode <= 3'd5;
    if (pc_ld && !(wr_en && wr_addr == 4'd15)) m_pc = pc_in;
    if (wr_en) begin
      if (wr_addr == 4'd15) m_pc = wr_data;
      else mset(cm, int'(wr_addr), wr_data);
    end
    if (bl_en) mset(cm, 14, pa);
    if (exv) begin
      mset(int'(exc_mode), 14, pa);
      m_spsr[exc_mode] = m_cpsr;
      m_cpsr = {m_cpsr[31:3], exc_mode};
    end else if (sr_wen) begin
      if (!sr_wsel) m_cpsr = sr_wdata;
      else if (cm != 0) m_spsr[cm] = sr_wdata;
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = 0; wr_data = 0; pc_ld = 0; pc_in = 0; bl_en = 0;
    exc_en = 0; exc_mode = 0; sr_wen = 0; sr_wsel = 0; sr_wdata = 0;
  endtask

  // Check outputs before the edge, advance, update the model, clear stimulus.
  task automatic tick();
    int cm;
    #1;
    cm = cur_m();
    chk(tag_of(int'(ra_addr)), "ra_data", ra_data, mget(cm, int'(ra_addr)));
    chk(tag_of(int'(rb_addr)), "rb_data", rb_data, mget(cm, int'(rb_addr)));
    chk(focus != "" ? focus : "R10", "sr_rdata", sr_rdata,
        (sr_rsel && cm != 0) ? m_spsr[cm] : m_cpsr);
    chk(focus != "" ? focus : "R11", "cpsr_o", cpsr_o, m_cpsr);
    chk(focus != "" ? focus : "R9", "mode_o", {29'd0, mode_o}, cm);
    chk(focus != "" ? focus : "R5", "pc_o", pc_o, m_pc);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_cpsr(logic [31:0] v);
    sr_wen = 1; sr_wsel = 0; sr_wdata = v; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(); ra_addr = 0; rb_addr = 0; sr_rsel = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state on every address
    focus = "R1";
    for (int a = 0; a < 16; a++) begin
      ra_addr = 4'(a); rb_addr = 4'(15 - a); sr_rsel = a[0]; tick();
    end

    // R2: same-cycle read sees the old value, next cycle the new one
    focus = "R2";
    ra_addr = 3; wr_en = 1; wr_addr = 3; wr_data = 32'hA5A5_0003; tick();
    ra_addr = 3; tick();

    // R3/R4: bank separation
    focus = "";
    set_cpsr(32'h0);
    for (int r = 0; r < 15; r++) begin
      wr_en = 1; wr_addr = 4'(r); wr_data = 32'h1000_0000 + 32'(r); tick();
    end
    set_cpsr(32'h1);
    wr_en = 1; wr_addr = 8; wr_data = 32'hF1F1_0008; tick();
    wr_en = 1; wr_addr = 13; wr_data = 32'hF1F1_000D; tick();
    ra_addr = 0; rb_addr = 8; tick();
    ra_addr = 13; rb_addr = 12; tick();
    set_cpsr(32'h2);
    ra_addr = 8; rb_addr = 13; tick();
    wr_en = 1; wr_addr = 13; wr_data = 32'h2222_000D; tick();
    set_cpsr(32'h0);
    ra_addr = 8; rb_addr = 13; tick();
    ra_addr = 7; rb_addr = 14; tick();

    // R6: branch-and-link beats a write to the same R14; PC low bits dropped
    focus = "R6";
    pc_ld = 1; pc_in = 32'h0000_1003; tick();
    bl_en = 1; wr_en = 1; wr_addr = 14; wr_data = 32'hDEAD_BEEF; ra_addr = 15; tick();
    ra_addr = 14; rb_addr = 15; tick();

    // R7: exception entry from user into interrupt mode
    focus = "R7";
    set_cpsr(32'hF000_0000);
    pc_ld = 1; pc_in = 32'h0000_2006; tick();
    exc_en = 1; exc_mode = 3'd2; tick();
    ra_addr = 14; sr_rsel = 1; tick();
    exc_en = 1; exc_mode = 3'd6; tick();
    exc_en = 1; exc_mode = 3'd0; ra_addr = 14; tick();
    sr_rsel = 0; tick();

    // R8: collisions in an exception cycle
    focus = "R8";
    exc_en = 1; exc_mode = 3'd3; sr_wen = 1; sr_wsel = 0; sr_wdata = 32'h5;
    wr_en = 1; wr_addr = 14; wr_data = 32'h1234_5678; bl_en = 1; tick();
    ra_addr = 14; sr_rsel = 1; tick();
    pc_ld = 1; pc_in = 32'h0000_3001; tick();
    exc_en = 1; exc_mode = 3'd3; wr_en = 1; wr_addr = 14; wr_data = 32'h8765_4321;
    sr_wen = 1; sr_wsel = 1; sr_wdata = 32'hCAFE_0000; tick();
    ra_addr = 14; sr_rsel = 1; tick();
    set_cpsr(32'h2);
    ra_addr = 14; tick();

    // R9: invalid mode bits behave as user
    focus = "R9";
    set_cpsr(32'h7);
    ra_addr = 13; rb_addr = 14; sr_rsel = 1; tick();
    set_cpsr(32'h6);
    ra_addr = 9; rb_addr = 13; tick();

    // R11/R10: saved status writes are dropped in user mode
    focus = "R11";
    sr_wen = 1; sr_wsel = 1; sr_wdata = 32'h0BAD_0BAD; sr_rsel = 1; tick();
    sr_rsel = 1; tick();
    set_cpsr(32'h4);
    sr_wen = 1; sr_wsel = 1; sr_wdata = 32'h0ABC_0004; tick();
    focus = "R10";
    sr_rsel = 1; tick();
    sr_rsel = 0; tick();

    // Random mix across all modes
    focus = "";
    for (int n = 0; n < 4000; n++) begin
      ra_addr  = 4'($urandom_range(0, 15));
      rb_addr  = 4'($urandom_range(0, 15));
      sr_rsel  = 1'($urandom_range(0, 1));
      wr_en    = ($urandom_range(0, 99) < 50);
      wr_addr  = 4'($urandom_range(0, 15));
      wr_data  = $urandom;
      pc_ld    = ($urandom_range(0, 99) < 20);
      pc_in    = $urandom;
      bl_en    = ($urandom_range(0, 99) < 10);
      exc_en   = ($urandom_range(0, 99) < 10);
      exc_mode = 3'($urandom_range(0, 7));
      sr_wen   = ($urandom_range(0, 99) < 15);
      sr_wsel  = 1'($urandom_range(0, 1));
      sr_wdata = {$urandom_range(0, 15) << 28, 25'd0, 3'($urandom_range(0, 7))};
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule